// File: doc/BRIEF.md
# Two-Operand Joint Normalizer

This combinational unit takes two unsigned W-bit mantissas. It shifts both of them left by one shared amount, chosen so that at least one of the results carries a 1 in its most significant bit. This is the kind of step needed before handing a pair of operands that share one scale factor to a complex multiplier or a rotation datapath. Both operands must keep the same relative scale, so they cannot be normalized independently.

The shared amount is the leading-zero count of the bitwise OR of the two operands. That count is never larger than the smaller of the two individual leading-zero counts. The count is resolved one bit at a time, starting from the bit of largest weight. Each resolved bit immediately drives the matching stage of a logarithmic shifter, so encoding and shifting proceed together down one chain of stages. Zeros enter at the least significant end. When both inputs are zero, a flag is raised, the outputs stay zero, and every stage reports itself as taken.

Top module: `dual_norm`

## Requirements
- R1: norm_a and norm_b equal opnd_a and opnd_b shifted left by exactly shamt positions, with zeros filling from bit 0 upward.
- R2: Whenever at least one operand is nonzero, bit W-1 of norm_a or of norm_b is 1.
- R3: When both operands are nonzero, shamt equals the smaller of their two leading-zero counts, where a count is the number of 0 bits above the highest 1 bit.
- R4: No 1 bit is shifted out: shifting norm_a and norm_b right by shamt gives back opnd_a and opnd_b.
- R5: When both operands are zero, both_zero is 1, norm_a and norm_b are 0, and shamt is W-1 (all bits set).
- R6: both_zero is 0 whenever any bit of either operand is 1.
- R7: When bit W-1 of either operand is 1, shamt is 0 and the outputs equal the inputs.
- R8: When exactly one operand is zero, shamt equals the leading-zero count of the other operand alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First unsigned mantissa |
| opnd_b | input | W | Second unsigned mantissa |
| norm_a | output | W | First operand after the shared left shift |
| norm_b | output | W | Second operand after the shared left shift |
| shamt | output | log2(W) | Shared shift amount, one bit per shifter stage |
| both_zero | output | 1 | Both operands are zero |

## Verification
A reference model computes the two leading-zero counts by loop, takes the smaller, and shifts both operands by it. The stimulus includes single-bit operands swept across every position in both operands. These separate a stage that tests the wrong window from one that shifts by the wrong weight. Pairs with one zero operand show that a zero operand does not pull the shift to its own count. Pairs with the top bit already set expose any spurious shift. The all-zero pair pins down the flag and the all-taken count, and random pairs with masked-off upper bits cover mixed stage patterns.

// File: rtl/dn_pkg.sv
package dn_pkg;

  // True when n is a positive power of two.
  function automatic bit is_pow2(input int n);
    return (n > 0) && ((n & (n - 1)) == 0);
  endfunction

  // Number of halving steps for a power-of-two width.
  function automatic int stage_count(input int n);
    int c;
    c = 0;
    while ((1 << c) < n) c++;
    return c;
  endfunction

endpackage

// File: rtl/dn_merge.sv
module dn_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] any_o
);
  // A bit position is occupied when either operand has a 1 there.
  assign any_o = x_i | y_i;
endmodule

// File: rtl/dn_stage.sv
module dn_stage #(
  parameter int W  = 32,
  parameter int SH = 16
) (
  input  logic [W-1:0] any_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] any_o,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o,
  output logic         take_o
);
  // Shift left by SH and fill the vacated low bits with zeros.
  function automatic logic [W-1:0] lift(input logic [W-1:0] v);
    return {v[W-1-SH:0], {SH{1'b0}}};
  endfunction

  logic window_empty;

  // The stage is taken when the top SH bits of the merged word are clear.
  assign window_empty = ~|any_i[W-1 -: SH];
  assign take_o       = window_empty;

  assign any_o = window_empty ? lift(any_i) : any_i;
  assign a_o   = window_empty ? lift(a_i)   : a_i;
  assign b_o   = window_empty ? lift(b_i)   : b_i;
endmodule

// File: rtl/dual_norm.sv
module dual_norm #(
  parameter int W = 32
) (
  input  logic [W-1:0]                   opnd_a,
  input  logic [W-1:0]                   opnd_b,
  output logic [W-1:0]                   norm_a,
  output logic [W-1:0]                   norm_b,
  output logic [dn_pkg::stage_count(W)-1:0] shamt,
  output logic                           both_zero
);
  localparam int L = dn_pkg::stage_count(W);

  initial begin
    if (!dn_pkg::is_pow2(W) || W < 2)
      $error("dual_norm: W must be a power of two of at least 2");
  end

  // Chains of partially shifted words; index 0 is the input side.
  logic [W-1:0] any_c [0:L];
  logic [W-1:0] a_c   [0:L];
  logic [W-1:0] b_c   [0:L];
  logic [L-1:0] take;

  dn_merge #(.W(W)) u_merge (
    .x_i   (opnd_a),
    .y_i   (opnd_b),
    .any_o (any_c[0])
  );

  assign a_c[0] = opnd_a;
  assign b_c[0] = opnd_b;

  // Stage g resolves count bit L-1-g, largest weight first.
  for (genvar g = 0; g < L; g++) begin : g_stage
    localparam int K = L - 1 - g;
    dn_stage #(.W(W), .SH(1 << K)) u_stage (
      .any_i  (any_c[g]),
      .a_i    (a_c[g]),
      .b_i    (b_c[g]),
      .any_o  (any_c[g+1]),
      .a_o    (a_c[g+1]),
      .b_o    (b_c[g+1]),
      .take_o (take[K])
    );
  end

  assign norm_a    = a_c[L];
  assign norm_b    = b_c[L];
  assign shamt     = take;
  // A nonzero merged word always ends with its top bit set.
  assign both_zero = ~any_c[L][W-1];
endmodule

// File: rtl/dual_norm_chk.sv
module dual_norm_chk #(
  parameter int W = 32
) (
  input logic [W-1:0]                      opnd_a,
  input logic [W-1:0]                      opnd_b,
  input logic [W-1:0]                      norm_a,
  input logic [W-1:0]                      norm_b,
  input logic [dn_pkg::stage_count(W)-1:0] shamt,
  input logic                              both_zero
);
  localparam int L = dn_pkg::stage_count(W);

  logic [W-1:0] ref_a, ref_b, back_a, back_b;
  assign ref_a  = opnd_a << shamt;
  assign ref_b  = opnd_b << shamt;
  assign back_a = norm_a >> shamt;
  assign back_b = norm_b >> shamt;

  always_comb begin
    a_r1_same_shift: assert (norm_a == ref_a && norm_b == ref_b)
      else $error("R1 outputs differ from inputs shifted by shamt");
    a_r2_normalized: assert (both_zero || norm_a[W-1] || norm_b[W-1])
      else $error("R2 no output normalized");
    a_r4_no_lost_bits: assert (back_a == opnd_a && back_b == opnd_b)
      else $error("R4 set bit shifted out");
    a_r5_zero_pair: assert (!both_zero || (shamt == L'(W-1) && norm_a == '0 && norm_b == '0))
      else $error("R5 zero pair not reported correctly");
    a_r6_flag_clear: assert (both_zero == (opnd_a == '0 && opnd_b == '0))
      else $error("R6 zero flag disagrees with operands");
    a_r7_top_set: assert (!(opnd_a[W-1] || opnd_b[W-1]) || shamt == '0)
      else $error("R7 shift applied to normalized operand");
  end
endmodule

bind dual_norm dual_norm_chk #(.W(W)) u_chk (
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .norm_a    (norm_a),
  .norm_b    (norm_b),
  .shamt     (shamt),
  .both_zero (both_zero)
);

// File: tb/test_dual_norm.sv
module test_dual_norm;
  localparam int W = 32;
  localparam int L = 5;

  typedef struct {
    logic [W-1:0] a, b, na, nb;
    logic [L-1:0] sh;
    logic         z;
    string        tag;
  } exp_t;

  logic clk = 0;
  always #10 clk = ~clk;

  logic [W-1:0] opnd_a = '0, opnd_b = '0, norm_a, norm_b;
  logic [L-1:0] shamt;
  logic         both_zero;

  dual_norm #(.W(W)) i_dual_norm (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .norm_a(norm_a), .norm_b(norm_b),
    .shamt(shamt), .both_zero(both_zero)
  );

  exp_t q[$];
  int applied = 0, miscompares = 0;
  bit driving_done = 0;

  function automatic int lead_zeros(logic [W-1:0] v);
    int n = 0;
    for (int i = W - 1; i >= 0; i--) begin
      if (v[i]) return n;
      n++;
    end
    return n;
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b);
    exp_t e;
    int za, zb, m;
    za = lead_zeros(a);
    zb = lead_zeros(b);
    @(posedge clk);
    #1;
    opnd_a = a;
    opnd_b = b;
    e.a = a; e.b = b;
    e.z = (a == '0) && (b == '0);
    if (e.z)            begin m = W - 1; e.tag = "R5"; end
    else if (a == '0)   begin m = zb;    e.tag = "R8"; end
    else if (b == '0)   begin m = za;    e.tag = "R8"; end
    else begin
      m = (za < zb) ? za : zb;
      e.tag = (a[W-1] || b[W-1]) ? "R7" : "R3";
    end
    e.sh = L'(m);
    e.na = e.z ? '0 : (a << m);
    e.nb = e.z ? '0 : (b << m);
    q.push_back(e);
  endtask

  // Monitor: compares half a cycle after each vector is driven.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = 0;
        applied++;
        if (shamt !== e.sh) begin
          bad = 1;
          $display("FAIL %s shamt a=%h b=%h actual %0d expected %0d", e.tag, e.a, e.b, shamt, e.sh);
        end
        if (norm_a !== e.na || norm_b !== e.nb) begin
          bad = 1;
          $display("FAIL R1 outputs a=%h b=%h actual %h/%h expected %h/%h", e.a, e.b, norm_a, norm_b, e.na, e.nb);
        end
        if (both_zero !== e.z) begin
          bad = 1;
          $display("FAIL %s both_zero a=%h b=%h actual %b expected %b", e.z ? "R5" : "R6", e.a, e.b, both_zero, e.z);
        end
        if (!e.z && !(norm_a[W-1] || norm_b[W-1])) begin
          bad = 1;
          $display("FAIL R2 top bits actual %b%b expected one set", norm_a[W-1], norm_b[W-1]);
        end
        if ((norm_a >> shamt) !== e.a || (norm_b >> shamt) !== e.b) begin
          bad = 1;
          $display("FAIL R4 recovered actual %h/%h expected %h/%h", norm_a >> shamt, norm_b >> shamt, e.a, e.b);
        end
        if (bad) miscompares++;
      end
    end
  end

  initial begin
    #200;
    drive('0, '0);                                 // R5 all-zero pair
    drive(32'h8000_0000, 32'h0000_0001);           // R7 top bit of a
    drive(32'h0000_0000, 32'hFFFF_FFFF);           // R7 and R8
    drive(32'h0000_0001, 32'h0000_0000);           // R8 deepest shift
    drive(32'h0001_0000, 32'h0000_8000);           // R3 crossing halves
    drive(32'h0000_00F0, 32'h0000_00F0);           // R3 equal operands
    for (int i = 0; i < W; i++) begin              // R3 R8 single-bit sweep
      drive(W'(1) << i, '0);
      drive('0, W'(1) << i);
      drive(W'(1) << i, W'(1) << ((i * 7) % W));
    end
    for (int i = 0; i < 400; i++) begin            // R3 mixed random depths
      logic [W-1:0] ra, rb;
      ra = $urandom() >> ($urandom() % W);
      rb = $urandom() >> ($urandom() % W);
      drive(ra, rb);
    end
    @(posedge clk);
    driving_done = 1;
  end

  initial begin
    wait (driving_done && q.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule